// File: doc/BRIEF.md
# Shared-Operand Rank-One and Matrix-Vector Unit

This block computes either of two products built around one stored vector M of runtime length N. In outer-product mode it writes the scaled rank-one matrix k1·MᵀM, one element per clock. In matrix-vector mode it reads a caller-owned matrix R and writes the scaled vector k2·R·Mᵀ, one element per row. A single datapath serves both modes. It has two chained multipliers and one accumulator, and the accumulator is used only in matrix-vector mode.

M is loaded into the block through a simple write port while the unit is idle. R is read through an address pair, and the data must come back on the next clock, as it would from a synchronous RAM. Results leave through two separate write ports, one for each destination memory. A run begins with one of two start strobes and ends with a single-cycle done pulse.

Top module: `rank1_matvec_unit`

## Requirements
- R1: A cycle with `m_we` high while `busy` is low stores `m_wdata` into entry `m_addr` of M. Any `m_we` while `busy` is high is ignored.
- R2: Numbers are signed 16-bit two's complement with 8 fractional bits. A fixed-point product is (a·b) shifted right arithmetically by 8 (rounding toward minus infinity) and then clamped to [-32768, 32767]. In outer-product mode, element (i,j) is mul(mul(k1, M[i]), M[j]). Elements are written on the `op_*` port one per cycle in row-major order. The first write appears 4 cycles after the clock edge that samples the start.
- R3: In matrix-vector mode, the block puts row i and column j on `r_row`/`r_col` and expects R[i][j] on `r_rdata` during the following cycle. Element i is the sum over j = 0..N-1, taken in ascending j, of mul(mul(k2, R[i][j]), M[j]). It is written on the `mv_*` port with index i, in ascending i. The first write appears N+4 cycles after the start edge.
- R4: Every product that leaves the representable range is replaced by 32767 or -32768 rather than wrapping.
- R5: Each accumulation step saturates to 32767 or -32768. Each row's sum starts fresh from that row's first term.
- R6: If `start_outer` and `start_mv` are both high in the same accepted cycle, only the outer product runs and no matrix-vector write occurs.
- R7: Start strobes that arrive while `busy` is high are ignored. A start with `n_len` equal to 0 or greater than 8 is ignored entirely: `busy` stays low and nothing is written.
- R8: `done` is high for exactly one cycle per run, in the cycle after the last write. That is N²+4 cycles after the start edge for outer-product mode and N²+5 for matrix-vector mode. `busy` is high from the cycle after an accepted start through the `done` cycle, and low afterwards.
- R9: The two write ports are never active in the same cycle. An outer-product run never writes the matrix-vector port, and a matrix-vector run never writes the outer-product port. Writes occur only while `busy` is high.
- R10: A run with length N writes exactly N² outer-product elements, or exactly N matrix-vector elements, all with indices below N.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| m_we | input | 1 | Write strobe for the stored vector M |
| m_addr | input | 3 | Element index for an M write |
| m_wdata | input | 16 | Element value for an M write |
| k1 | input | 16 | Scale for outer-product mode, sampled at start |
| k2 | input | 16 | Scale for matrix-vector mode, sampled at start |
| n_len | input | 4 | Runtime length N, sampled at start |
| start_outer | input | 1 | Start strobe for the outer product |
| start_mv | input | 1 | Start strobe for the matrix-vector product |
| r_row | output | 3 | Row address into R |
| r_col | output | 3 | Column address into R |
| r_rdata | input | 16 | R data, valid one cycle after the address |
| op_we | output | 1 | Write strobe for the outer-product memory |
| op_row | output | 3 | Row index of the outer-product write |
| op_col | output | 3 | Column index of the outer-product write |
| op_wdata | output | 16 | Outer-product element value |
| mv_we | output | 1 | Write strobe for the matrix-vector memory |
| mv_idx | output | 3 | Index of the matrix-vector write |
| mv_wdata | output | 16 | Matrix-vector element value |
| busy | output | 1 | High while a run is in progress |
| done | output | 1 | One-cycle end-of-run pulse |

## Verification
The bench builds the block with its package defaults: 16-bit words, 8 fractional bits and a maximum length of 8. A maximum length of 8 makes it cheap to sweep every legal N from 1 to 8 in both modes and over more than one data pattern, so every element of every result size is compared with an arithmetic model. Short runs with N = 2 and N = 4 on extreme operands reach product clamping and accumulation clamping directly. Lengths 0 and 9 exercise the rejection of illegal lengths, and a mid-run poke of both starts and an M write exercises the busy-time lockout.

// File: rtl/rmv_pkg.sv
package rmv_pkg;
    localparam int DW    = 16;
    localparam int FRAC  = 8;
    localparam int MAX_N = 8;
    localparam int IDX_W = (MAX_N > 1) ? $clog2(MAX_N) : 1;
    localparam int LEN_W = $clog2(MAX_N + 1);

    typedef logic signed [DW-1:0] word_t;
    typedef logic [IDX_W-1:0]     idx_t;
    typedef logic [LEN_W-1:0]     len_t;

    typedef enum logic {
        FN_OUTER  = 1'b0,
        FN_MATVEC = 1'b1
    } fn_e;

    // one element in flight through the datapath
    typedef struct packed {
        logic vld;
        idx_t row;
        idx_t col;
        logic row_first;
        logic row_last;
        logic final_el;
    } slot_t;

    localparam word_t WORD_MAX = {1'b0, {(DW-1){1'b1}}};
    localparam word_t WORD_MIN = {1'b1, {(DW-1){1'b0}}};

    // fixed-point multiply: floor shift by FRAC, clamp to word range
    function automatic word_t fx_mul(word_t a, word_t b);
        logic signed [2*DW-1:0] full;
        logic signed [2*DW-1:0] shf;
        full = $signed({{DW{a[DW-1]}}, a}) * $signed({{DW{b[DW-1]}}, b});
        shf  = full >>> FRAC;
        if (shf > $signed({{(DW+1){1'b0}}, {(DW-1){1'b1}}}))
            return WORD_MAX;
        if (shf < $signed({{(DW+1){1'b1}}, {(DW-1){1'b0}}}))
            return WORD_MIN;
        return shf[DW-1:0];
    endfunction

    // saturating add
    function automatic word_t fx_add(word_t a, word_t b);
        logic signed [DW:0] s;
        s = {a[DW-1], a} + {b[DW-1], b};
        if (s[DW] != s[DW-1])
            return s[DW] ? WORD_MIN : WORD_MAX;
        return s[DW-1:0];
    endfunction
endpackage

// File: rtl/rmv_vec_store.sv
module rmv_vec_store
    import rmv_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  wr_en,
    input  idx_t  wr_addr,
    input  word_t wr_data,
    input  idx_t  rd_a_addr,
    input  idx_t  rd_b_addr,
    output word_t rd_a,
    output word_t rd_b
);
    word_t cells [MAX_N];

    for (genvar g = 0; g < MAX_N; g++) begin : g_cell
        word_t cell_q;
        always_ff @(posedge clk) begin
            if (rst)
                cell_q <= '0;
            else if (wr_en && wr_addr == idx_t'(g))
                cell_q <= wr_data;
        end
        assign cells[g] = cell_q;
    end

    // two registered read ports: row operand and column operand
    always_ff @(posedge clk) begin
        if (rst) begin
            rd_a <= '0;
            rd_b <= '0;
        end else begin
            rd_a <= cells[rd_a_addr];
            rd_b <= cells[rd_b_addr];
        end
    end
endmodule

// File: rtl/rmv_seq.sv
module rmv_seq
    import rmv_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  start_outer,
    input  logic  start_mv,
    input  len_t  n_len,
    input  word_t k1,
    input  word_t k2,
    input  logic  fin,
    output logic  busy,
    output fn_e   fn,
    output word_t scale,
    output slot_t slot
);
    logic  run_q;
    logic  issuing_q;
    idx_t  row_q;
    idx_t  col_q;
    idx_t  last_q;
    fn_e   fn_q;
    word_t scale_q;

    logic any_start;
    logic len_ok;
    logic accept;

    assign any_start = start_outer | start_mv;
    assign len_ok    = (n_len != '0) && (n_len <= len_t'(MAX_N));
    assign accept    = !run_q && any_start && len_ok;

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q     <= 1'b0;
            issuing_q <= 1'b0;
            row_q     <= '0;
            col_q     <= '0;
            last_q    <= '0;
            fn_q      <= FN_OUTER;
            scale_q   <= '0;
        end else if (accept) begin
            run_q     <= 1'b1;
            issuing_q <= 1'b1;
            row_q     <= '0;
            col_q     <= '0;
            last_q    <= idx_t'(n_len - len_t'(1));
            // outer product wins a simultaneous request
            fn_q      <= start_outer ? FN_OUTER : FN_MATVEC;
            scale_q   <= start_outer ? k1 : k2;
        end else begin
            if (issuing_q) begin
                if (col_q == last_q) begin
                    col_q <= '0;
                    if (row_q == last_q)
                        issuing_q <= 1'b0;
                    else
                        row_q <= row_q + idx_t'(1);
                end else begin
                    col_q <= col_q + idx_t'(1);
                end
            end
            if (fin)
                run_q <= 1'b0;
        end
    end

    assign busy  = run_q;
    assign fn    = fn_q;
    assign scale = scale_q;

    always_comb begin
        slot.vld       = issuing_q;
        slot.row       = row_q;
        slot.col       = col_q;
        slot.row_first = (col_q == '0);
        slot.row_last  = (col_q == last_q);
        slot.final_el  = (col_q == last_q) && (row_q == last_q);
    end
endmodule

// File: rtl/rmv_datapath.sv
module rmv_datapath
    import rmv_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  fn_e   fn,
    input  word_t scale,
    input  slot_t slot_in,
    input  word_t m_row_val,
    input  word_t m_col_val,
    input  word_t r_val,
    output logic  op_we,
    output idx_t  op_row,
    output idx_t  op_col,
    output word_t op_wdata,
    output logic  mv_we,
    output idx_t  mv_idx,
    output word_t mv_wdata,
    output logic  done
);
    localparam int PIPE = 3;

    slot_t tag_q [PIPE];
    slot_t tail;
    word_t x1;
    word_t pa_q;
    word_t mj_q;
    word_t pb_q;
    word_t acc_q;
    word_t acc_nx;
    logic  mv_we_q;
    idx_t  mv_idx_q;
    word_t mv_wdata_q;
    logic  mv_last_q;
    logic  done_q;
    logic  is_mv;

    assign is_mv = (fn == FN_MATVEC);

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < PIPE; s++)
                tag_q[s] <= '0;
        end else begin
            tag_q[0] <= slot_in;
            for (int s = 1; s < PIPE; s++)
                tag_q[s] <= tag_q[s-1];
        end
    end

    assign tail = tag_q[PIPE-1];

    // first multiplier input: M row operand or R element
    assign x1 = is_mv ? r_val : m_row_val;

    always_ff @(posedge clk) begin
        if (rst) begin
            pa_q <= '0;
            mj_q <= '0;
            pb_q <= '0;
        end else begin
            pa_q <= fx_mul(scale, x1);
            mj_q <= m_col_val;
            pb_q <= fx_mul(pa_q, mj_q);
        end
    end

    assign acc_nx = tail.row_first ? pb_q : fx_add(acc_q, pb_q);

    assign op_we    = tail.vld && !is_mv;
    assign op_row   = tail.row;
    assign op_col   = tail.col;
    assign op_wdata = pb_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q      <= '0;
            mv_we_q    <= 1'b0;
            mv_idx_q   <= '0;
            mv_wdata_q <= '0;
            mv_last_q  <= 1'b0;
            done_q     <= 1'b0;
        end else begin
            if (tail.vld && is_mv)
                acc_q <= acc_nx;
            mv_we_q    <= tail.vld && is_mv && tail.row_last;
            mv_idx_q   <= tail.row;
            mv_wdata_q <= acc_nx;
            mv_last_q  <= tail.vld && is_mv && tail.final_el;
            done_q     <= (op_we && tail.final_el) || (mv_we_q && mv_last_q);
        end
    end

    assign mv_we    = mv_we_q;
    assign mv_idx   = mv_idx_q;
    assign mv_wdata = mv_wdata_q;
    assign done     = done_q;
endmodule

// File: rtl/rank1_matvec_unit.sv
module rank1_matvec_unit
    import rmv_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    m_we,
    input  logic [IDX_W-1:0]        m_addr,
    input  logic signed [DW-1:0]    m_wdata,
    input  logic signed [DW-1:0]    k1,
    input  logic signed [DW-1:0]    k2,
    input  logic [LEN_W-1:0]        n_len,
    input  logic                    start_outer,
    input  logic                    start_mv,
    output logic [IDX_W-1:0]        r_row,
    output logic [IDX_W-1:0]        r_col,
    input  logic signed [DW-1:0]    r_rdata,
    output logic                    op_we,
    output logic [IDX_W-1:0]        op_row,
    output logic [IDX_W-1:0]        op_col,
    output logic signed [DW-1:0]    op_wdata,
    output logic                    mv_we,
    output logic [IDX_W-1:0]        mv_idx,
    output logic signed [DW-1:0]    mv_wdata,
    output logic                    busy,
    output logic                    done
);
    fn_e   fn;
    word_t scale;
    slot_t slot;
    word_t m_row_val;
    word_t m_col_val;
    logic  run_busy;
    logic  run_done;

    rmv_seq u_seq (
        .clk        (clk),
        .rst        (rst),
        .start_outer(start_outer),
        .start_mv   (start_mv),
        .n_len      (n_len),
        .k1         (k1),
        .k2         (k2),
        .fin        (run_done),
        .busy       (run_busy),
        .fn         (fn),
        .scale      (scale),
        .slot       (slot)
    );

    rmv_vec_store u_vec (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (m_we && !run_busy),
        .wr_addr  (m_addr),
        .wr_data  (m_wdata),
        .rd_a_addr(slot.row),
        .rd_b_addr(slot.col),
        .rd_a     (m_row_val),
        .rd_b     (m_col_val)
    );

    rmv_datapath u_dp (
        .clk      (clk),
        .rst      (rst),
        .fn       (fn),
        .scale    (scale),
        .slot_in  (slot),
        .m_row_val(m_row_val),
        .m_col_val(m_col_val),
        .r_val    (r_rdata),
        .op_we    (op_we),
        .op_row   (op_row),
        .op_col   (op_col),
        .op_wdata (op_wdata),
        .mv_we    (mv_we),
        .mv_idx   (mv_idx),
        .mv_wdata (mv_wdata),
        .done     (run_done)
    );

    assign r_row = slot.row;
    assign r_col = slot.col;
    assign busy  = run_busy;
    assign done  = run_done;
endmodule

// File: rtl/rmv_checker.sv
module rmv_checker (
    input logic clk,
    input logic rst,
    input logic start_outer,
    input logic start_mv,
    input logic busy,
    input logic done,
    input logic op_we,
    input logic mv_we
);
    // R9
    wr_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(op_we && mv_we));

    // R9
    wr_in_run_chk: assert property (@(posedge clk) disable iff (rst)
        (op_we || mv_we) |-> busy);

    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R8
    done_in_run_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> busy);

    // R8
    done_idle_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !busy);

    // R7
    busy_rise_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(start_outer || start_mv));
endmodule

bind rank1_matvec_unit rmv_checker u_rmv_checker (
    .clk        (clk),
    .rst        (rst),
    .start_outer(start_outer),
    .start_mv   (start_mv),
    .busy       (busy),
    .done       (done),
    .op_we      (op_we),
    .mv_we      (mv_we)
);

// File: tb/rank1_matvec_unit_bench.sv
module rank1_matvec_unit_bench;
    import rmv_pkg::*;

    localparam int NM   = MAX_N;
    localparam int VMAX = (1 << (DW - 1)) - 1;
    localparam int VMIN = -(1 << (DW - 1));
    localparam int NONE = 999999;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic                 rst = 1'b1;
    logic                 m_we = 1'b0;
    logic [IDX_W-1:0]     m_addr = '0;
    logic signed [DW-1:0] m_wdata = '0;
    logic signed [DW-1:0] k1 = '0;
    logic signed [DW-1:0] k2 = '0;
    logic [LEN_W-1:0]     n_len = '0;
    logic                 start_outer = 1'b0;
    logic                 start_mv = 1'b0;
    logic [IDX_W-1:0]     r_row;
    logic [IDX_W-1:0]     r_col;
    logic signed [DW-1:0] r_rdata = '0;
    logic                 op_we;
    logic [IDX_W-1:0]     op_row;
    logic [IDX_W-1:0]     op_col;
    logic signed [DW-1:0] op_wdata;
    logic                 mv_we;
    logic [IDX_W-1:0]     mv_idx;
    logic signed [DW-1:0] mv_wdata;
    logic                 busy;
    logic                 done;

    rank1_matvec_unit u_rank1_matvec_unit (
        .clk(clk), .rst(rst), .m_we(m_we), .m_addr(m_addr), .m_wdata(m_wdata),
        .k1(k1), .k2(k2), .n_len(n_len), .start_outer(start_outer), .start_mv(start_mv),
        .r_row(r_row), .r_col(r_col), .r_rdata(r_rdata),
        .op_we(op_we), .op_row(op_row), .op_col(op_col), .op_wdata(op_wdata),
        .mv_we(mv_we), .mv_idx(mv_idx), .mv_wdata(mv_wdata),
        .busy(busy), .done(done)
    );

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    always @(posedge clk) cyc <= cyc + 1;

    // bench-side memories
    int mvec [NM];
    int rmat [NM][NM];
    always @(posedge clk) r_rdata <= DW'(rmat[r_row][r_col]);

    // monitor state
    int cur_n = 1;
    int start_cyc = 0;
    int got_op [NM][NM];
    int got_mv [NM];
    int op_cnt, mv_cnt, done_cnt, busy_cnt, bad_idx, order_err;
    int first_op_cyc, first_mv_cyc, done_cyc;

    always @(negedge clk) begin
        if (!rst) begin
            if (busy) busy_cnt++;
            if (op_we) begin
                if (op_cnt == 0) first_op_cyc = cyc;
                if (int'(op_row) >= cur_n || int'(op_col) >= cur_n) bad_idx++;
                else got_op[op_row][op_col] = op_wdata;
                if (int'(op_row) != op_cnt / cur_n || int'(op_col) != op_cnt % cur_n) order_err++;
                op_cnt++;
            end
            if (mv_we) begin
                if (mv_cnt == 0) first_mv_cyc = cyc;
                if (int'(mv_idx) >= cur_n) bad_idx++;
                else got_mv[mv_idx] = mv_wdata;
                if (int'(mv_idx) != mv_cnt) order_err++;
                mv_cnt++;
            end
            if (done) begin
                done_cnt++;
                done_cyc = cyc;
            end
        end
    end

    task automatic chk(string rq, string what, int act, int exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", rq, what, act, exp);
        end
    endtask

    function automatic int bsat(longint v);
        if (v > VMAX) return VMAX;
        if (v < VMIN) return VMIN;
        return int'(v);
    endfunction

    function automatic int bmul(int a, int b);
        longint p;
        p = longint'(a) * longint'(b);
        p = p >>> FRAC;
        return bsat(p);
    endfunction

    function automatic int badd(int a, int b);
        return bsat(longint'(a) + longint'(b));
    endfunction

    function automatic int pat(int seed, int a, int b);
        return ((a * 37 + b * 91 + seed * 53) % 201) - 100;
    endfunction

    task automatic load_m_pat(int seed, int mul);
        for (int i = 0; i < NM; i++) begin
            mvec[i] = pat(seed, i, 7) * mul;
            m_we = 1'b1; m_addr = IDX_W'(i); m_wdata = DW'(mvec[i]);
            @(negedge clk);
        end
        m_we = 1'b0;
    endtask

    task automatic load_m_const(int v);
        for (int i = 0; i < NM; i++) begin
            mvec[i] = v;
            m_we = 1'b1; m_addr = IDX_W'(i); m_wdata = DW'(v);
            @(negedge clk);
        end
        m_we = 1'b0;
    endtask

    task automatic load_r_pat(int seed, int mul);
        for (int i = 0; i < NM; i++)
            for (int j = 0; j < NM; j++)
                rmat[i][j] = pat(seed, i, j) * mul;
    endtask

    task automatic kick(bit so, bit sm, int n, int kk1, int kk2, int poke_at, int max_wait);
        op_cnt = 0; mv_cnt = 0; done_cnt = 0; busy_cnt = 0; bad_idx = 0; order_err = 0;
        first_op_cyc = NONE; first_mv_cyc = NONE; done_cyc = NONE;
        for (int i = 0; i < NM; i++) begin
            got_mv[i] = NONE;
            for (int j = 0; j < NM; j++) got_op[i][j] = NONE;
        end
        cur_n = (n > 0) ? n : 1;
        start_outer = so; start_mv = sm;
        n_len = LEN_W'(n); k1 = DW'(kk1); k2 = DW'(kk2);
        start_cyc = cyc;
        for (int w = 1; w < max_wait; w++) begin
            @(negedge clk);
            start_outer = 1'b0; start_mv = 1'b0; m_we = 1'b0;
            if (w == poke_at) begin
                start_outer = 1'b1; start_mv = 1'b1;
                m_we = 1'b1; m_addr = '0; m_wdata = DW'(12345);
            end
            if (done_cnt > 0 && w > poke_at) break;
        end
        start_outer = 1'b0; start_mv = 1'b0; m_we = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic check_outer(string rq, int n, int kk1);
        for (int i = 0; i < n; i++)
            for (int j = 0; j < n; j++)
                chk(rq, $sformatf("outer n=%0d (%0d,%0d)", n, i, j), got_op[i][j],
                    bmul(bmul(kk1, mvec[i]), mvec[j]));
        chk("R10", "outer write count", op_cnt, n * n);
        chk("R10", "index range", bad_idx, 0);
        chk("R2", "row-major order", order_err, 0);
        chk("R2", "first write latency", first_op_cyc - start_cyc, 4);
        chk("R9", "mv writes in outer run", mv_cnt, 0);
        chk("R8", "done pulses", done_cnt, 1);
        chk("R8", "done latency outer", done_cyc - start_cyc, n * n + 4);
        chk("R8", "busy cycles", busy_cnt, n * n + 4);
        chk("R8", "busy after done", int'(busy), 0);
    endtask

    task automatic check_mv(string rq, int n, int kk2);
        for (int i = 0; i < n; i++) begin
            int acc = 0;
            for (int j = 0; j < n; j++) begin
                int p = bmul(bmul(kk2, rmat[i][j]), mvec[j]);
                acc = (j == 0) ? p : badd(acc, p);
            end
            chk(rq, $sformatf("matvec n=%0d row %0d", n, i), got_mv[i], acc);
        end
        chk("R10", "mv write count", mv_cnt, n);
        chk("R10", "index range", bad_idx, 0);
        chk("R3", "ascending index", order_err, 0);
        chk("R3", "first mv write latency", first_mv_cyc - start_cyc, n + 4);
        chk("R9", "outer writes in mv run", op_cnt, 0);
        chk("R8", "done pulses", done_cnt, 1);
        chk("R8", "done latency mv", done_cyc - start_cyc, n * n + 5);
        chk("R8", "busy after done", int'(busy), 0);
    endtask

    initial begin
        for (int i = 0; i < NM; i++) begin
            mvec[i] = 0;
            for (int j = 0; j < NM; j++) rmat[i][j] = 0;
        end
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // reset state, R8 and R9
        chk("R8", "busy after reset", int'(busy), 0);
        chk("R8", "done after reset", int'(done), 0);
        chk("R9", "op_we after reset", int'(op_we), 0);
        chk("R9", "mv_we after reset", int'(mv_we), 0);

        // sweeps over every legal length, two data sets; R1 reload between sets
        for (int seed = 1; seed <= 2; seed++) begin
            load_m_pat(seed, 13 * seed);
            load_r_pat(seed + 5, 17);
            for (int n = 1; n <= NM; n++) begin
                kick(1'b1, 1'b0, n, 384 - 200 * seed, 0, -1, 400);
                check_outer("R2", n, 384 - 200 * seed);
                kick(1'b0, 1'b1, n, 0, 192 - 500 * seed, -1, 400);
                check_mv("R3", n, 192 - 500 * seed);
            end
        end

        // R4 product clamping, both signs
        load_m_const(30000);
        mvec[0] = -30000;
        m_we = 1'b1; m_addr = '0; m_wdata = DW'(-30000);
        @(negedge clk);
        m_we = 1'b0;
        kick(1'b1, 1'b0, 2, 25600, 0, -1, 400);
        check_outer("R4", 2, 25600);
        chk("R4", "positive clamp (1,1)", got_op[1][1], VMAX);
        chk("R4", "negative clamp (0,1)", got_op[0][1], VMIN);
        chk("R4", "neg*neg clamp (0,0)", got_op[0][0], VMAX);

        // R5 accumulation clamping; row 1 negative
        load_m_const(2560);
        for (int j = 0; j < NM; j++) begin
            rmat[0][j] = 2560; rmat[1][j] = -2560;
            rmat[2][j] = (j == 0) ? 2560 : 0;
            rmat[3][j] = (j < 2) ? 1280 : -256;
        end
        kick(1'b0, 1'b1, 4, 0, 256, -1, 400);
        check_mv("R5", 4, 256);
        chk("R5", "sum clamps high", got_mv[0], VMAX);
        chk("R5", "sum clamps low", got_mv[1], VMIN);
        chk("R5", "row restarts", got_mv[2], 25600);

        // R6 simultaneous starts
        load_m_pat(3, 11);
        kick(1'b1, 1'b1, 5, 300, 500, -1, 400);
        check_outer("R6", 5, 300);
        chk("R6", "mv writes after dual start", mv_cnt, 0);

        // R7 and R1: starts and an M write poked mid-run are ignored
        kick(1'b1, 1'b0, 8, -256, 0, 10, 400);
        check_outer("R1", 8, -256);
        chk("R7", "mv writes after busy start", mv_cnt, 0);
        chk("R7", "single run after busy start", done_cnt, 1);
        kick(1'b1, 1'b0, 1, 256, 0, -1, 400);
        chk("R1", "M[0] kept after busy write", got_op[0][0], bmul(bmul(256, mvec[0]), mvec[0]));

        // R7 illegal lengths
        kick(1'b1, 1'b0, 0, 256, 0, -1, 20);
        chk("R7", "n=0 busy cycles", busy_cnt, 0);
        chk("R7", "n=0 writes", op_cnt + mv_cnt, 0);
        chk("R7", "n=0 done", done_cnt, 0);
        kick(1'b0, 1'b1, NM + 1, 0, 256, -1, 20);
        chk("R7", "n=9 busy cycles", busy_cnt, 0);
        chk("R7", "n=9 writes", op_cnt + mv_cnt, 0);
        chk("R7", "n=9 done", done_cnt, 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    always @(posedge clk) begin
        if (cyc == 150000) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end
endmodule